// File: doc/BRIEF.md
# Serial EEPROM Slave Model

This block is a synthesizable stand-in for a small serial EEPROM on an SPI bus in mode 0. The clock is idle low, the slave samples data on the rising clock edge and changes its output after the falling edge, and bits travel most significant first. It runs entirely on the system clock. The three bus inputs pass through a synchronizer, and the block finds the serial clock edges by oversampling them. Its contents live in an internal byte array, and reset fills every byte with 0xFF, the erased value.

Each transaction begins with a one-byte opcode. The opcodes cover the following:
- setting and clearing the write-enable latch;
- reading and writing a status register;
- reading a stream of bytes from any address;
- writing up to one page.

Written data goes first into a page buffer. It reaches the array only at the end of the transaction, during a timed write cycle that keeps a busy flag set. The address is `ADDR_BYTES` bytes long. An option lets opcode bit 3 carry the address bit just above the bytes sent, which doubles the reach of a one-byte-address part.

Top module: `spi_ee_model`

## Requirements
- R1: After reset the status register reads 0x00, every array byte reads 0xFF, and `miso` is 0 whenever `cs_n` is high.
- R2: A transaction with opcode 0x06 sets the write-enable latch, which is status bit 1. Opcode 0x04 clears it.
- R3: Opcode 0x05 returns the status byte on every following byte while `cs_n` stays low. The status bits are: bit 7 the protect-enable flag, bits 3:2 the two protect bits, bit 1 the write-enable latch, bit 0 busy. Bits 6:4 read 0.
- R4: Opcode 0x01 with the latch set stores bits 7, 3 and 2 of the first data byte into the status register when `cs_n` rises, ignores the other bits, and starts a write cycle. For a data byte of 0xFF, the status reads 0x8F during the cycle and 0x8C after it.
- R5: Opcode 0x03 is followed by `ADDR_BYTES` address bytes, most significant first. The block then returns bytes from consecutive addresses, wrapping from the last array address to 0.
- R6: Opcode 0x02 with the latch set takes an address and then data bytes. Within a page, the write address wraps back to the first byte of the same page. The data reaches the array only after `cs_n` rises.
- R7: Opcodes 0x01 and 0x02 received while the write-enable latch is clear are ignored: no write cycle starts and the array is unchanged.
- R8: A write or status-write transaction commits only if `cs_n` rises on a byte boundary after at least one data byte. Otherwise nothing changes, and the latch keeps its value.
- R9: A committed write holds status bit 0 at 1 for `WRITE_CYCLES` clock cycles. It then clears both busy and the write-enable latch.
- R10: While busy, only opcode 0x05 is obeyed. Every other opcode is ignored, and `miso` stays 0 for the rest of that transaction.
- R11: With `ADDR_BIT3_EN` set, opcodes 0x0B and 0x0A act as read and write. Their bit 3 (0x08) supplies address bit 8*`ADDR_BYTES`.
- R12: An unknown opcode, such as 0x07 or 0x0E, changes nothing, and `miso` stays 0 for the rest of the transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the serial clock high and low phases each last at least 6 periods of it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cs_n | input | 1 | Chip select, active low; its rising edge ends a transaction |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data into the slave, sampled on the rising edge of `sck` |
| miso | output | 1 | Serial data out of the slave, updated after the falling edge of `sck`; 0 when not selected |

## Verification
The bench builds the block with one address byte, a 512-byte array, 16-byte pages, the opcode bit 3 option enabled and a 2000-cycle write cycle. The array is twice the span of the address byte, so opcode bit 3 is the only way to reach the upper half. This puts the bit 3 decode and the wrap from 0x1FF to 0x000 within reach of short transactions. The short write cycle allows status to be polled both inside and after a cycle, and allows commands to be sent while busy, all within the run's budget.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  localparam logic [7:0] OPC_LATCH_ON  = 8'h06;
  localparam logic [7:0] OPC_LATCH_OFF = 8'h04;
  localparam logic [7:0] OPC_STAT_GET  = 8'h05;
  localparam logic [7:0] OPC_STAT_PUT  = 8'h01;
  localparam logic [7:0] OPC_DATA_GET  = 8'h03;
  localparam logic [7:0] OPC_DATA_PUT  = 8'h02;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_RDAT,
    ST_RSTS,
    ST_WDAT,
    ST_WSTS,
    ST_SKIP
  } ee_state_t;

endpackage

// File: rtl/spi_ee_front.sv
module spi_ee_front #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n_i,
  input  logic       sck_i,
  input  logic       mosi_i,
  input  logic [7:0] tx_byte_i,
  output logic       miso_o,
  output logic       sel_o,
  output logic       cs_rise_o,
  output logic       whole_o,
  output logic       byte_vld_o,
  output logic [7:0] rx_byte_o
);

  logic [SYNC:0]   cs_q, sck_q;
  logic [SYNC-1:0] mosi_q;
  logic [2:0]      bit_q, bit_nx;
  logic [6:0]      sh_q, sh_nx;
  logic [7:0]      rx_q, rx_nx;
  logic            vld_q, vld_nx;
  logic            miso_q, miso_nx;
  logic            sck_rise, sck_fall, mosi_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= '1;
      sck_q  <= '0;
      mosi_q <= '0;
    end else begin
      cs_q   <= {cs_q[SYNC-1:0], cs_n_i};
      sck_q  <= {sck_q[SYNC-1:0], sck_i};
      mosi_q <= {mosi_q[SYNC-2:0], mosi_i};
    end
  end

  always_comb begin
    sck_rise  = sck_q[SYNC-1] & ~sck_q[SYNC];
    sck_fall  = ~sck_q[SYNC-1] & sck_q[SYNC];
    mosi_s    = mosi_q[SYNC-1];
    sel_o     = ~cs_q[SYNC-1];
    cs_rise_o = cs_q[SYNC-1] & ~cs_q[SYNC];
    whole_o   = (bit_q == 3'd0);
    bit_nx    = bit_q;
    sh_nx     = sh_q;
    rx_nx     = rx_q;
    vld_nx    = 1'b0;
    miso_nx   = miso_q;
    if (!sel_o) begin
      bit_nx  = 3'd0;
      miso_nx = 1'b0;
    end else begin
      if (sck_rise) begin
        sh_nx  = {sh_q[5:0], mosi_s};
        bit_nx = bit_q + 3'd1;
        if (bit_q == 3'd7) begin
          vld_nx = 1'b1;
          rx_nx  = {sh_q, mosi_s};
        end
      end
      if (sck_fall) miso_nx = tx_byte_i[3'd7 - bit_q];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      vld_q  <= 1'b0;
      miso_q <= 1'b0;
    end else begin
      bit_q  <= bit_nx;
      sh_q   <= sh_nx;
      rx_q   <= rx_nx;
      vld_q  <= vld_nx;
      miso_q <= miso_nx;
    end
  end

  assign miso_o     = miso_q;
  assign byte_vld_o = vld_q;
  assign rx_byte_o  = rx_q;

endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
  parameter int MEM_BYTES = 512,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [8*MEM_BYTES-1:0] flat;

  for (genvar g = 0; g < MEM_BYTES; g++) begin : g_cell
    logic [7:0] cell_q;
    logic       cell_en;
    assign cell_en = we && (waddr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q <= 8'hFF;
      else if (cell_en) cell_q <= wdata;
    end
    assign flat[8*g +: 8] = cell_q;
  end

  assign rdata = flat[{raddr, 3'b000} +: 8];

endmodule

// File: rtl/spi_ee_core.sv
module spi_ee_core
  import spi_ee_pkg::*;
#(
  parameter int ADDR_BYTES   = 1,
  parameter int MEM_BYTES    = 512,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 500000,
  parameter bit ADDR_BIT3_EN = 1'b1,
  localparam int AW  = $clog2(MEM_BYTES),
  localparam int PW  = $clog2(PAGE_BYTES),
  localparam int SW  = 8 * ADDR_BYTES,
  localparam int CYC = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES,
  localparam int TW  = $clog2(CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          cs_rise,
  input  logic          whole,
  input  logic          byte_vld,
  input  logic [7:0]    rx_byte,
  output logic [7:0]    tx_byte,
  output logic [AW-1:0] mem_raddr,
  input  logic [7:0]    mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata
);

  localparam logic [PW:0] SEQ_END = (PW+1)'(PAGE_BYTES);

  ee_state_t         st_q, st_nx;
  logic              op3_q, op3_nx, rd_q, rd_nx;
  logic [1:0]        acnt_q, acnt_nx;
  logic [SW-1:0]     ash_q, ash_nx, ash_sh;
  logic [AW-1:0]     raddr_q, raddr_nx, addr_full;
  logic [7:0]        tx_q, tx_nx, status, opm;
  logic [AW-PW-1:0]  pbase_q, pbase_nx;
  logic [PW-1:0]     poff_q, poff_nx;
  logic [PAGE_BYTES-1:0] pvld_q, pvld_nx;
  logic [7:0]        pbuf_q [PAGE_BYTES];
  logic              buf_we;
  logic [2:0]        sdat_q, sdat_nx;
  logic              sgot_q, sgot_nx;
  logic              wel_q, wel_nx, wpen_q, wpen_nx;
  logic [1:0]        bp_q, bp_nx;
  logic              busy_q, busy_nx, arr_q, arr_nx;
  logic [TW-1:0]     tmr_q, tmr_nx;
  logic [PW:0]       seq_q, seq_nx;

  assign status    = {wpen_q, 3'b000, bp_q, wel_q, busy_q};
  assign ash_sh    = (ash_q << 8) | SW'(rx_byte);
  assign addr_full = AW'({op3_q, ash_sh});
  assign opm       = ADDR_BIT3_EN ? {rx_byte[7:4], 1'b0, rx_byte[2:0]} : rx_byte;
  assign mem_raddr = (st_q == ST_ADDR) ? addr_full : raddr_q;
  assign tx_byte   = tx_q;
  assign mem_we    = busy_q && arr_q && (seq_q != SEQ_END) && pvld_q[seq_q[PW-1:0]];
  assign mem_waddr = {pbase_q, seq_q[PW-1:0]};
  assign mem_wdata = pbuf_q[seq_q[PW-1:0]];

  always_comb begin
    st_nx = st_q;     op3_nx = op3_q;     rd_nx = rd_q;
    acnt_nx = acnt_q; ash_nx = ash_q;     raddr_nx = raddr_q;
    tx_nx = tx_q;     pbase_nx = pbase_q; poff_nx = poff_q;
    pvld_nx = pvld_q; sdat_nx = sdat_q;   sgot_nx = sgot_q;
    wel_nx = wel_q;   bp_nx = bp_q;       wpen_nx = wpen_q;
    busy_nx = busy_q; arr_nx = arr_q;     tmr_nx = tmr_q;
    seq_nx = seq_q;   buf_we = 1'b0;
    if (busy_q) begin
      if (seq_q != SEQ_END) seq_nx = seq_q + 1'b1;
      if (tmr_q == '0) begin
        busy_nx = 1'b0;
        wel_nx  = 1'b0;
      end else begin
        tmr_nx = tmr_q - 1'b1;
      end
    end
    if (!sel) begin
      st_nx = ST_OPC;
      tx_nx = 8'h00;
      if (cs_rise && whole) begin
        if (st_q == ST_WDAT && (|pvld_q)) begin
          busy_nx = 1'b1; arr_nx = 1'b1;
          tmr_nx  = TW'(CYC - 1); seq_nx = '0;
        end else if (st_q == ST_WSTS && sgot_q) begin
          busy_nx = 1'b1; arr_nx = 1'b0;
          tmr_nx  = TW'(CYC - 1); seq_nx = '0;
          wpen_nx = sdat_q[2];
          bp_nx   = sdat_q[1:0];
        end
      end
    end else if (byte_vld) begin
      case (st_q)
        ST_OPC: begin
          st_nx   = ST_SKIP;
          tx_nx   = 8'h00;
          op3_nx  = ADDR_BIT3_EN ? rx_byte[3] : 1'b0;
          acnt_nx = 2'(ADDR_BYTES - 1);
          ash_nx  = '0;
          if (rx_byte == OPC_STAT_GET) begin
            st_nx = ST_RSTS;
            tx_nx = status;
          end else if (!busy_q) begin
            if (rx_byte == OPC_LATCH_ON)       wel_nx = 1'b1;
            else if (rx_byte == OPC_LATCH_OFF) wel_nx = 1'b0;
            else if (rx_byte == OPC_STAT_PUT && wel_q) begin
              st_nx = ST_WSTS; sgot_nx = 1'b0;
            end else if (opm == OPC_DATA_GET) begin
              st_nx = ST_ADDR; rd_nx = 1'b1;
            end else if (opm == OPC_DATA_PUT && wel_q) begin
              st_nx = ST_ADDR; rd_nx = 1'b0; pvld_nx = '0;
            end
          end
        end
        ST_ADDR: begin
          ash_nx = ash_sh;
          if (acnt_q == 2'd0) begin
            if (rd_q) begin
              st_nx    = ST_RDAT;
              tx_nx    = mem_rdata;
              raddr_nx = addr_full + 1'b1;
            end else begin
              st_nx    = ST_WDAT;
              pbase_nx = addr_full[AW-1:PW];
              poff_nx  = addr_full[PW-1:0];
            end
          end else begin
            acnt_nx = acnt_q - 2'd1;
          end
        end
        ST_RDAT: begin
          tx_nx    = mem_rdata;
          raddr_nx = raddr_q + 1'b1;
        end
        ST_RSTS: tx_nx = status;
        ST_WDAT: begin
          buf_we           = 1'b1;
          pvld_nx[poff_q]  = 1'b1;
          poff_nx          = poff_q + 1'b1;
        end
        ST_WSTS: begin
          if (!sgot_q) begin
            sdat_nx = {rx_byte[7], rx_byte[3:2]};
            sgot_nx = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_OPC;  op3_q <= 1'b0;  rd_q <= 1'b0;
      acnt_q <= '0;    ash_q <= '0;    raddr_q <= '0;
      tx_q <= '0;      pbase_q <= '0;  poff_q <= '0;
      pvld_q <= '0;    sdat_q <= '0;   sgot_q <= 1'b0;
      wel_q <= 1'b0;   bp_q <= '0;     wpen_q <= 1'b0;
      busy_q <= 1'b0;  arr_q <= 1'b0;  tmr_q <= '0;
      seq_q <= '0;
    end else begin
      st_q <= st_nx;   op3_q <= op3_nx; rd_q <= rd_nx;
      acnt_q <= acnt_nx; ash_q <= ash_nx; raddr_q <= raddr_nx;
      tx_q <= tx_nx;   pbase_q <= pbase_nx; poff_q <= poff_nx;
      pvld_q <= pvld_nx; sdat_q <= sdat_nx; sgot_q <= sgot_nx;
      wel_q <= wel_nx; bp_q <= bp_nx;   wpen_q <= wpen_nx;
      busy_q <= busy_nx; arr_q <= arr_nx; tmr_q <= tmr_nx;
      seq_q <= seq_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf_q[poff_q] <= rx_byte;
  end

  AST_CYCLE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(wel_q)); // R7

  AST_LATCH_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> !wel_q); // R9

  AST_COMMIT_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(cs_rise && whole)); // R8

  AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (st_q != ST_WDAT && st_q != ST_WSTS)); // R10

endmodule

// File: rtl/spi_ee_model.sv
module spi_ee_model #(
  parameter int ADDR_BYTES   = 1,
  parameter int MEM_BYTES    = 512,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 500000,
  parameter bit ADDR_BIT3_EN = 1'b1,
  parameter int SYNC         = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso
);

  localparam int AW = $clog2(MEM_BYTES);

  logic [1:0]    rst_q;
  logic          rst_s;
  logic          sel, cs_rise, whole, byte_vld;
  logic [7:0]    rx_byte, tx_byte, mem_rdata, mem_wdata;
  logic [AW-1:0] mem_raddr, mem_waddr;
  logic          mem_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_s = rst_q[1];

  spi_ee_front #(.SYNC(SYNC)) i_front (
    .clk(clk), .rst_n(rst_s), .cs_n_i(cs_n), .sck_i(sck), .mosi_i(mosi),
    .tx_byte_i(tx_byte), .miso_o(miso), .sel_o(sel), .cs_rise_o(cs_rise),
    .whole_o(whole), .byte_vld_o(byte_vld), .rx_byte_o(rx_byte)
  );

  spi_ee_core #(
    .ADDR_BYTES(ADDR_BYTES), .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES),
    .WRITE_CYCLES(WRITE_CYCLES), .ADDR_BIT3_EN(ADDR_BIT3_EN)
  ) i_core (
    .clk(clk), .rst_n(rst_s), .sel(sel), .cs_rise(cs_rise), .whole(whole),
    .byte_vld(byte_vld), .rx_byte(rx_byte), .tx_byte(tx_byte),
    .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  spi_ee_array #(.MEM_BYTES(MEM_BYTES)) i_array (
    .clk(clk), .rst_n(rst_s), .we(mem_we), .waddr(mem_waddr),
    .wdata(mem_wdata), .raddr(mem_raddr), .rdata(mem_rdata)
  );

endmodule

// File: tb/test_spi_ee_model.sv
module test_spi_ee_model;

  localparam int HALF = 8;
  localparam int NV   = 6;
  localparam logic [16:0] VEC [NV] = '{
    {9'h000, 8'h11}, {9'h001, 8'h22}, {9'h0FF, 8'h33},
    {9'h100, 8'h44}, {9'h1FF, 8'h55}, {9'h180, 8'h66}
  };

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso;
  logic [7:0] d, s, s2;
  logic [7:0] rb [8];
  logic [7:0] wb [8];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_ee_model #(.ADDR_BYTES(1), .MEM_BYTES(512), .PAGE_BYTES(16),
                 .WRITE_CYCLES(2000), .ADDR_BIT3_EN(1'b1)) i_spi_ee_model (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi), .miso(miso));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      tick(HALF);
      rx[i] = miso;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic sel_on();
    tick(2); cs_n = 1'b0; tick(HALF);
  endtask

  task automatic sel_off();
    tick(HALF); cs_n = 1'b1; tick(3 * HALF);
  endtask

  task automatic cmd(input logic [7:0] op);
    sel_on(); xbyte(op, d); sel_off();
  endtask

  task automatic rdsr(output logic [7:0] st);
    sel_on(); xbyte(8'h05, d); xbyte(8'h00, st); sel_off();
  endtask

  task automatic wrsr(input logic [7:0] v);
    sel_on(); xbyte(8'h01, d); xbyte(v, d); sel_off();
  endtask

  task automatic rd(input logic [8:0] a, input int n);
    sel_on();
    xbyte(8'h03 | {4'b0000, a[8], 3'b000}, d);
    xbyte(a[7:0], d);
    for (int i = 0; i < n; i++) xbyte(8'h00, rb[i]);
    sel_off();
  endtask

  task automatic wr(input logic [8:0] a, input int n);
    sel_on();
    xbyte(8'h02 | {4'b0000, a[8], 3'b000}, d);
    xbyte(a[7:0], d);
    for (int i = 0; i < n; i++) xbyte(wb[i], d);
    sel_off();
  endtask

  task automatic wait_rdy();
    logic [7:0] st;
    for (int k = 0; k < 40; k++) begin
      rdsr(st);
      if (st[0] == 1'b0) break;
    end
  endtask

  initial begin : watchdog
    tick(190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    tick(5); rst_n = 1'b1; tick(5);
    checks++;
    if (miso !== 1'b0) begin
      errors++;
      $display("FAIL R1 miso idle actual %b expected 0", miso);
    end
    rdsr(s);   chk("R1 status after reset", s, 8'h00);
    rd(9'h000, 1); chk("R1 erased byte", rb[0], 8'hFF);

    cmd(8'h06); rdsr(s); chk("R2 latch set", s, 8'h02);
    cmd(8'h04); rdsr(s); chk("R2 latch clear", s, 8'h00);

    cmd(8'h06);
    sel_on(); xbyte(8'h05, d); xbyte(8'h00, s); xbyte(8'h00, s2); sel_off();
    chk("R3 status byte 1", s, 8'h02);
    chk("R3 status byte 2", s2, 8'h02);
    cmd(8'h04);

    for (int v = 0; v < NV; v++) begin
      cmd(8'h06);
      wb[0] = VEC[v][7:0];
      wr(VEC[v][16:8], 1);
      wait_rdy();
      rd(VEC[v][16:8], 1);
      chk(VEC[v][16] ? "R11 upper write/read" : "R6 single write/read", rb[0], VEC[v][7:0]);
    end

    rd(9'h1FF, 3);
    chk("R5 last byte", rb[0], 8'h55);
    chk("R5 wrap to 0", rb[1], 8'h11);
    chk("R5 next", rb[2], 8'h22);
    rd(9'h100, 1); chk("R11 bit3 selects upper", rb[0], 8'h44);
    rd(9'h000, 1); chk("R11 no bit3 lower", rb[0], 8'h11);

    cmd(8'h06);
    wb[0] = 8'hA1; wb[1] = 8'hB2; wb[2] = 8'hC3; wb[3] = 8'hD4;
    wr(9'h01E, 4); wait_rdy();
    rd(9'h01E, 2); chk("R6 page byte E", rb[0], 8'hA1); chk("R6 page byte F", rb[1], 8'hB2);
    rd(9'h010, 2); chk("R6 wrapped byte 0", rb[0], 8'hC3); chk("R6 wrapped byte 1", rb[1], 8'hD4);
    rd(9'h020, 1); chk("R6 next page untouched", rb[0], 8'hFF);

    cmd(8'h06); wb[0] = 8'h77; wr(9'h040, 1);
    rdsr(s); chk("R9 busy at start", s, 8'h03);
    tick(1100);
    rdsr(s); chk("R9 still busy", s, 8'h03);
    tick(700);
    rdsr(s); chk("R9 done and latch clear", s, 8'h00);
    rd(9'h040, 1); chk("R9 data committed", rb[0], 8'h77);

    cmd(8'h06); wb[0] = 8'h88; wr(9'h041, 1);
    rd(9'h000, 1); chk("R10 read ignored while busy", rb[0], 8'h00);
    cmd(8'h04);
    rdsr(s); chk("R10 latch clear ignored while busy", s, 8'h03);
    wait_rdy();
    rd(9'h041, 1); chk("R10 data after cycle", rb[0], 8'h88);

    wb[0] = 8'h99; wr(9'h041, 1);
    rdsr(s); chk("R7 no cycle without latch", s, 8'h00);
    rd(9'h041, 1); chk("R7 array unchanged", rb[0], 8'h88);
    wrsr(8'h8C);
    rdsr(s); chk("R7 status write ignored", s, 8'h00);

    cmd(8'h06);
    sel_on(); xbyte(8'h02, d); xbyte(8'h41, d); xbyte(8'h5A, d); xbits(8'hF0, 3, d); sel_off();
    rdsr(s); chk("R8 partial byte no cycle", s, 8'h02);
    rd(9'h041, 1); chk("R8 array unchanged", rb[0], 8'h88);
    sel_on(); xbyte(8'h02, d); xbyte(8'h41, d); sel_off();
    rdsr(s); chk("R8 no data byte no cycle", s, 8'h02);

    wrsr(8'hFF);
    rdsr(s); chk("R4 status during cycle", s, 8'h8F);
    wait_rdy();
    rdsr(s); chk("R4 status after cycle", s, 8'h8C);
    cmd(8'h06); wrsr(8'h00); wait_rdy();
    rdsr(s); chk("R4 status cleared", s, 8'h00);

    sel_on(); xbyte(8'h07, d); xbyte(8'h00, s2); sel_off();
    chk("R12 unknown opcode output", s2, 8'h00);
    cmd(8'h0E);
    rdsr(s); chk("R12 no latch from 0x0E", s, 8'h00);

    cmd(8'h06);
    tick(2); rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(5);
    rdsr(s); chk("R1 status after second reset", s, 8'h00);
    rd(9'h000, 1); chk("R1 array erased again", rb[0], 8'hFF);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule